// File: doc/BRIEF.md
# Software-Driven SPI Pin Port

This block is a memory-mapped SPI port in which software sets each pin state itself. A small 32-bit register bus reaches four registers: a mode register, a free-form control register, a pin register and a capture register. When the mode bit is set, the pin register drives the serial clock, the serial data output and three active-low chip selects directly. Software produces each clock pulse by writing the pin register twice: once with the clock bit low and the next data bit set up, then once with the clock bit high. The clock idles low and data is presented before the rising edge, which is SPI mode 0.

Each write that moves the clock bit from 0 to 1 shifts the capture register left by one place and loads the serial data input into bit 0. After a word has been clocked, the capture register holds the received bits with the first bit received in the most significant of them. When the mode bit is clear, the pins are handed to a separate memory-mapped flash read engine. That engine's pin requests enter the block as inputs and are passed straight through to the pins.

Top module: `bb_spi_port`

## Requirements
- R1: After reset the mode register reads 0, the control register reads 0, the pin register reads 0x0007_0000 (all chip selects high, clock and data low) and the capture register reads 0.
- R2: Bus address bits [3:2] select the register: 0 mode, 1 control, 2 pins, 3 capture. A read request returns the data with busRdValid high on the next cycle only.
- R3: The mode register stores only bit 0. Its other bits always read 0.
- R4: The control register stores all 32 bits written to it and holds them until the next write to it.
- R5: The pin register stores all 32 bits written to it and reads them back unchanged.
- R6: While mode bit 0 is 1, spiMosi follows pin-register bit 0, spiSclk follows bit 8, and spiCsN[n] follows bit 16+n for n = 0..2.
- R7: While mode bit 0 is 0, spiSclk, spiMosi and spiCsN follow memSclk, memMosi and memCsN.
- R8: While mode bit 0 is 1, a pin-register write that changes bit 8 from 0 to 1 shifts the capture register left by one and loads spiMiso, as sampled in the cycle of that write, into bit 0.
- R9: The capture register does not change on a pin-register write that leaves bit 8 at 1, that clears it, or that occurs while mode bit 0 is 0.
- R10: Writes to the capture register (address 0x0C) are ignored.
- R11: After an N-bit mode-0 transfer (N up to 32), the low N bits of the capture register hold the received bits, first bit received in bit N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe, completes in one cycle |
| busRdEn | input | 1 | Register read request |
| busAddr | input | 4 | Byte address; bits [3:2] select the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | High for one cycle, the cycle after busRdEn |
| memSclk | input | 1 | Clock requested by the flash read engine |
| memMosi | input | 1 | Data output requested by the flash read engine |
| memCsN | input | 3 | Chip selects requested by the flash read engine |
| spiMiso | input | 1 | Serial data input pin |
| spiSclk | output | 1 | Serial clock pin |
| spiMosi | output | 1 | Serial data output pin |
| spiCsN | output | 3 | Active-low chip-select pins |

## Verification
The transfer path is exercised with every 8-bit outgoing value, each paired with a different incoming pattern, plus a few full 32-bit words. This separates errors in bit order, errors in the shift direction and off-by-one faults in the sample point. The pin mapping is swept over all combinations of the five driven pin bits and all combinations of the five flash-engine inputs, so a swapped or stuck pin shows up in both modes. Pin writes that repeat a high clock, lower the clock, or arrive with the mode bit off are interleaved with real rising edges. This tells edge detection apart from level detection and confirms the mode gate.

// File: rtl/bb_spi_pkg.sv
package bb_spi_pkg;

  // register selected by address bits [3:2]
  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_PINS  = 2'd2,
    SEL_CAPT  = 2'd3
  } regSel_t;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic    wrMode;
    logic    wrCtrl;
    logic    wrPins;
    logic    rdReq;
    regSel_t rdSel;
  } busStrobe_t;

  // pin register field positions (decoded by the pin drivers)
  localparam int unsigned DOUT_BIT = 0;
  localparam int unsigned SCLK_BIT = 8;
  localparam int unsigned CS_LSB   = 16;

endpackage

// File: rtl/bb_spi_ctrl.sv
module bb_spi_ctrl
  import bb_spi_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe,
  output logic              busRdValid
);

  localparam int unsigned SEL_LSB = 2;

  regSel_t addrSel;
  logic    rdValidQ;

  assign addrSel = regSel_t'(busAddr[SEL_LSB +: 2]);

  always_comb begin
    strobe        = '0;
    strobe.rdReq  = busRdEn;
    strobe.rdSel  = addrSel;
    if (busWrEn) begin
      unique case (addrSel)
        SEL_MODE: strobe.wrMode = 1'b1;
        SEL_CTRL: strobe.wrCtrl = 1'b1;
        SEL_PINS: strobe.wrPins = 1'b1;
        SEL_CAPT: ;  // capture register is read-only
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= busRdEn;
  end

  assign busRdValid = rdValidQ;

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);

  // R2
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);

  // R10
  capt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[SEL_LSB +: 2] == 2'd3) |->
      !(strobe.wrMode || strobe.wrCtrl || strobe.wrPins));

endmodule

// File: rtl/bb_spi_datapath.sv
module bb_spi_datapath
  import bb_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              memSclk,
  input  logic              memMosi,
  input  logic [NUM_CS-1:0] memCsN,
  input  logic              spiMiso,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic [NUM_CS-1:0] spiCsN
);

  localparam logic [DATA_W-1:0] PINS_RESET =
    DATA_W'(((64'd1 << NUM_CS) - 64'd1) << CS_LSB);

  logic              modeEn;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] pinsReg;
  logic [DATA_W-1:0] captReg;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] rdMux;
  logic              clkRise;

  // a write that raises the clock bit while the port owns the pins
  assign clkRise = modeEn && strobe.wrPins &&
                   busWrData[SCLK_BIT] && !pinsReg[SCLK_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn  <= 1'b0;
      ctrlReg <= '0;
      pinsReg <= PINS_RESET;
      captReg <= '0;
    end else begin
      if (strobe.wrMode) modeEn  <= busWrData[0];
      if (strobe.wrCtrl) ctrlReg <= busWrData;
      if (strobe.wrPins) pinsReg <= busWrData;
      if (clkRise)       captReg <= {captReg[DATA_W-2:0], spiMiso};
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_MODE: rdMux = {{(DATA_W-1){1'b0}}, modeEn};
      SEL_CTRL: rdMux = ctrlReg;
      SEL_PINS: rdMux = pinsReg;
      SEL_CAPT: rdMux = captReg;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdDataQ <= '0;
    else if (strobe.rdReq) rdDataQ <= rdMux;
  end

  assign busRdData = rdDataQ;

  // pin ownership: bit-bang register or flash read engine
  assign spiSclk = modeEn ? pinsReg[SCLK_BIT] : memSclk;
  assign spiMosi = modeEn ? pinsReg[DOUT_BIT] : memMosi;

  for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
    assign spiCsN[n] = modeEn ? pinsReg[CS_LSB + n] : memCsN[n];
  end

  // R8
  shift_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeEn) && pinsReg[SCLK_BIT] && !$past(pinsReg[SCLK_BIT])) |->
      (captReg == {$past(captReg[DATA_W-2:0]), $past(spiMiso)}));

  // R9
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !($past(modeEn) && pinsReg[SCLK_BIT] && !$past(pinsReg[SCLK_BIT])) |->
      $stable(captReg));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCtrl |=> $stable(ctrlReg));

  // R3
  mode_read_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && strobe.rdSel == SEL_MODE) |=>
      (busRdData[DATA_W-1:1] == '0));

endmodule

// File: rtl/bb_spi_port.sv
module bb_spi_port
  import bb_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdValid,
  input  logic              memSclk,
  input  logic              memMosi,
  input  logic [NUM_CS-1:0] memCsN,
  input  logic              spiMiso,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic [NUM_CS-1:0] spiCsN
);

  busStrobe_t strobe;

  bb_spi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .strobe     (strobe),
    .busRdValid (busRdValid)
  );

  bb_spi_datapath #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .memSclk   (memSclk),
    .memMosi   (memMosi),
    .memCsN    (memCsN),
    .spiMiso   (spiMiso),
    .spiSclk   (spiSclk),
    .spiMosi   (spiMosi),
    .spiCsN    (spiCsN)
  );

endmodule

// File: tb/bb_spi_port_tb.sv
module bb_spi_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic        memSclk = 1'b0;
  logic        memMosi = 1'b0;
  logic [2:0]  memCsN = 3'b111;
  logic        spiMiso = 1'b0;
  logic        spiSclk;
  logic        spiMosi;
  logic [2:0]  spiCsN;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] captModel = '0;
  logic [31:0] pinsModel = 32'h0007_0000;
  logic        modeModel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bb_spi_port u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdValid(busRdValid), .memSclk(memSclk), .memMosi(memMosi),
    .memCsN(memCsN), .spiMiso(spiMiso), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiCsN(spiCsN)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // write; the bench model follows the requirements
  task automatic writeReg(input logic [3:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    case (addr[3:2])
      2'd0: modeModel = data[0];
      2'd2: begin
        if (modeModel && data[8] && !pinsModel[8])
          captModel = {captModel[30:0], spiMiso};
        pinsModel = data;
      end
      default: ;
    endcase
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] addr, output logic [31:0] data);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr;
    @(negedge clk);
    busRdEn = 1'b0;
    checks++;
    if (busRdValid !== 1'b1) begin
      failures++;
      $display("FAIL R2 rdValid actual=%b expected=1", busRdValid);
    end
    data = busRdData;
    @(negedge clk);
    checks++;
    if (busRdValid !== 1'b0) begin
      failures++;
      $display("FAIL R2 rdValid pulse actual=%b expected=0", busRdValid);
    end
  endtask

  task automatic expectPins(input string tag, input logic s, input logic m,
                            input logic [2:0] c);
    check(tag, {29'd0, s, m, 1'b0} | {26'd0, c, 3'd0},
               {29'd0, spiSclk, spiMosi, 1'b0} | {26'd0, spiCsN, 3'd0});
  endtask

  // mode-0 transfer of nbits, msb first; rx bits drive spiMiso
  task automatic transfer(input int nbits, input logic [31:0] tx,
                          input logic [31:0] rx);
    logic [31:0] base;
    logic [31:0] rd;
    logic [31:0] mask;
    base = 32'h0006_0000;  // cs0 low, others high
    for (int i = nbits - 1; i >= 0; i--) begin
      writeReg(4'h8, base | {31'd0, tx[i]});
      check("R6 mosi setup", {31'd0, spiMosi}, {31'd0, tx[i]});
      spiMiso = rx[i];
      writeReg(4'h8, base | {31'd0, tx[i]} | 32'h100);
      check("R6 sclk high", {31'd0, spiSclk}, 32'd1);
    end
    writeReg(4'h8, base);
    readReg(4'hC, rd);
    mask = (nbits == 32) ? 32'hFFFF_FFFF : ((32'd1 << nbits) - 32'd1);
    check("R11 word", rd & mask, rx & mask);
    check("R8 capture", rd, captModel);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    readReg(4'h0, rd); check("R1 mode", rd, 32'h0);
    readReg(4'h4, rd); check("R1 ctrl", rd, 32'h0);
    readReg(4'h8, rd); check("R1 pins", rd, 32'h0007_0000);
    readReg(4'hC, rd); check("R1 capt", rd, 32'h0);

    // R7 flash engine owns pins when mode is off
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      memSclk = v[0]; memMosi = v[1]; memCsN = v[4:2];
      @(negedge clk);
      expectPins("R7 passthrough", v[0], v[1], v[4:2]);
    end

    // R9 clock rise with mode off: no capture
    spiMiso = 1'b1;
    writeReg(4'h8, 32'h0007_0100);
    writeReg(4'h8, 32'h0007_0000);
    readReg(4'hC, rd); check("R9 mode off", rd, 32'h0);

    // R3 mode register
    writeReg(4'h0, 32'hFFFF_FFFF);
    readReg(4'h0, rd); check("R3 mode bits", rd, 32'h1);
    writeReg(4'h0, 32'hFFFF_FFFE);
    readReg(4'h0, rd); check("R3 mode clear", rd, 32'h0);

    // R4 control register
    writeReg(4'h4, 32'h43);
    readReg(4'h4, rd); check("R4 ctrl 0x43", rd, 32'h43);
    for (int b = 0; b < 32; b++) begin
      writeReg(4'h4, 32'd1 << b);
      writeReg(4'h0, 32'h0);
      readReg(4'h4, rd); check("R4 walk", rd, 32'd1 << b);
    end

    // R5 / R6 pin register in bit-bang mode, all five driven bits
    writeReg(4'h0, 32'h1);
    for (int v = 0; v < 32; v++) begin
      logic [31:0] w;
      w = {13'd0, v[4:2], 7'd0, v[1], 7'd0, v[0]} | 32'hA0A0_0E0E;
      writeReg(4'h8, w);
      expectPins("R6 drive", v[1], v[0], v[4:2]);
      readReg(4'h8, rd); check("R5 readback", rd, w);
    end
    readReg(4'hC, rd); check("R8 sweep capture", rd, captModel);

    // R10 capture register not writable
    readReg(4'hC, held);
    writeReg(4'hC, ~held);
    readReg(4'hC, rd); check("R10 ignored", rd, held);

    // R9 held high, falling, no rise
    writeReg(4'h8, 32'h0006_0000);
    spiMiso = 1'b0;
    writeReg(4'h8, 32'h0006_0100);
    readReg(4'hC, held);
    spiMiso = ~spiMiso;
    writeReg(4'h8, 32'h0006_0101);
    readReg(4'hC, rd); check("R9 held high", rd, held);
    writeReg(4'h8, 32'h0006_0001);
    readReg(4'hC, rd); check("R9 falling", rd, held);

    // R8 / R11 every 8-bit word
    for (int w = 0; w < 256; w++) begin
      logic [7:0] rxb;
      rxb = 8'(w * 37 + 91) ^ 8'h5A;
      transfer(8, 32'(w), {24'd0, rxb});
    end

    // R11 full-width words and short words
    transfer(32, 32'hDEAD_BEEF, 32'h8000_0001);
    transfer(32, 32'h1234_5678, 32'hC3A5_5A3C);
    transfer(1, 32'h1, 32'h1);
    transfer(5, 32'h15, 32'h0A);

    // R7 returning pins to flash engine
    writeReg(4'h0, 32'h0);
    @(negedge clk);
    memSclk = 1'b1; memMosi = 1'b0; memCsN = 3'b010;
    @(negedge clk);
    expectPins("R7 handback", 1'b1, 1'b0, 3'b010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule